// File: doc/BRIEF.md
# GPIO Interrupt Channel Selector

This block turns chosen GPIO pins into interrupt requests. It has eight interrupt lines. Each line has its own 7-bit pin selector, so it can watch any one of 62 synchronous GPIO inputs. A line fires on the level of its pin, on a single edge of its pin, or on any transition of its pin. A per-line polarity bit picks active-high or active-low for level mode, and rising or falling for single-edge mode. One global enable bit gates all eight lines together.

Software sets the block up through a plain 32-bit register port. A write takes effect at the next clock edge. Read data is combinational from the read address. There is one control word, and there are four selector words that each hold the selectors of two neighbouring lines. Interrupt outputs are registered. A level line follows its pin one clock late. An edge line gives a single-clock pulse in the cycle after the clock edge that first samples the new pin value. All traffic is register access or plain wires, so the block has no valid/ready handshake and never applies back-pressure.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset, all registers read as zero, the global enable is off and every `irq_out` bit is 0.
- R2: The control word sits at byte offset 0x00. Bit 31 is the global enable. Bits [23:16] hold the per-line any-transition bits, bits [15:8] hold the per-line edge-mode bits (1 = edge, 0 = level), and bits [7:0] hold the per-line polarity bits, with line n at bit n of each field. Bits [30:24] read as zero.
- R3: While the global enable is 0, every `irq_out` bit is 0 in the following cycle, whatever the pins and the other settings.
- R4: The selector of line c sits at byte offset 0x04 + 4*(c/2). An even line uses bits [6:0] and an odd line uses bits [22:16]. All other bits of these words read as zero.
- R5: A selector value from 62 to 127 connects no pin, and that line never asserts in any mode.
- R6: In level mode, `irq_out[c]` equals the selected pin XOR the polarity bit, one clock after the pin is sampled. Polarity 0 means active-high and 1 means active-low.
- R7: In single-edge mode, with polarity 0 a line pulses for one clock on a 0-to-1 change between two consecutive clock samples of its pin. With polarity 1 it pulses on a 1-to-0 change. No other condition makes it pulse.
- R8: When a line's any-transition bit is set, the line pulses for one clock on every change of its pin between consecutive samples, and its edge-mode and polarity bits have no effect.
- R9: In the cycle after a write to a line's selector word, that line (in single-edge or any-transition mode) does not pulse, even if the newly selected pin differs from the previously selected one.
- R10: Reads of any offset other than 0x00, 0x04, 0x08, 0x0C and 0x10 (misaligned offsets included) return zero. Writes to those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte offset of the read |
| rd_data | output | 32 | Combinational read data |
| gpio_in | input | 62 | GPIO inputs, synchronous to clk |
| irq_out | output | 8 | Interrupt lines |

## Verification
The properties assume that `gpio_in` is already synchronous to `clk` and that the register inputs hold known values once reset is released. Edge and level relations are stated between consecutive clock samples, so a pin that changes between edges is only seen at the next edge. The bench changes pins, writes and read addresses only at falling edges. It draws write offsets from the mapped set plus a few unmapped and misaligned ones, so every decoded and undecoded case is reached. Selector values are biased so that about one in ten lands in the unconnected 62–127 range.

// File: rtl/gir_pkg.sv
package gir_pkg;
  localparam int NUM_PINS     = 62;
  localparam int NUM_CH       = 8;
  localparam int SEL_W        = 7;
  localparam int DATA_W       = 32;
  localparam int ADDR_W       = 8;
  localparam int NUM_SEL_REGS = NUM_CH / 2;
  localparam int SEL_SPAN     = 2 ** SEL_W;
  localparam int REG_STRIDE   = 4;
  localparam int CTRL_OFS     = 0;
  localparam int SEL_BASE     = 4;

  // control word field positions
  localparam int POL_LSB  = 0;
  localparam int MODE_LSB = 8;
  localparam int ANY_LSB  = 16;
  localparam int GEN_BIT  = 31;

  // selector word field positions
  localparam int EVEN_LSB = 0;
  localparam int ODD_LSB  = 16;

  typedef logic [SEL_W-1:0] sel_t;

  typedef struct packed {
    logic              gen;
    logic [NUM_CH-1:0] any_tr;
    logic [NUM_CH-1:0] edge_mode;
    logic [NUM_CH-1:0] pol;
  } ctrl_t;

  function automatic logic [DATA_W-1:0] ctrl_word(ctrl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[GEN_BIT]              = c.gen;
    w[ANY_LSB  +: NUM_CH]   = c.any_tr;
    w[MODE_LSB +: NUM_CH]   = c.edge_mode;
    w[POL_LSB  +: NUM_CH]   = c.pol;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] sel_word(sel_t ev, sel_t od);
    logic [DATA_W-1:0] w;
    w = '0;
    w[EVEN_LSB +: SEL_W] = ev;
    w[ODD_LSB  +: SEL_W] = od;
    return w;
  endfunction
endpackage

// File: rtl/gir_regs.sv
module gir_regs
  import gir_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [DATA_W-1:0]             rd_data,
  output ctrl_t                         ctrl_q,
  output logic [NUM_CH-1:0][SEL_W-1:0]  sel_q,
  output logic [NUM_CH-1:0]             sel_wr
);
  logic ctrl_hit;
  assign ctrl_hit = wr_en && (wr_addr == ADDR_W'(CTRL_OFS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_hit) begin
      ctrl_q.gen       <= wr_data[GEN_BIT];
      ctrl_q.any_tr    <= wr_data[ANY_LSB  +: NUM_CH];
      ctrl_q.edge_mode <= wr_data[MODE_LSB +: NUM_CH];
      ctrl_q.pol       <= wr_data[POL_LSB  +: NUM_CH];
    end
  end

  // one selector word per pair of lines
  for (genvar k = 0; k < NUM_SEL_REGS; k++) begin : g_selw
    logic       hit;
    sel_t       even_q;
    sel_t       odd_q;
    assign hit = wr_en && (wr_addr == ADDR_W'(SEL_BASE + REG_STRIDE * k));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        even_q <= '0;
        odd_q  <= '0;
      end else if (hit) begin
        even_q <= wr_data[EVEN_LSB +: SEL_W];
        odd_q  <= wr_data[ODD_LSB  +: SEL_W];
      end
    end

    assign sel_q[2*k]    = even_q;
    assign sel_q[2*k+1]  = odd_q;
    assign sel_wr[2*k]   = hit;
    assign sel_wr[2*k+1] = hit;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(CTRL_OFS)) rd_data = ctrl_word(ctrl_q);
    for (int k = 0; k < NUM_SEL_REGS; k++) begin
      if (rd_addr == ADDR_W'(SEL_BASE + REG_STRIDE * k))
        rd_data = sel_word(sel_q[2*k], sel_q[2*k+1]);
    end
  end
endmodule

// File: rtl/gir_mux.sv
module gir_mux
  import gir_pkg::*;
(
  input  logic [NUM_PINS-1:0]          gpio_in,
  input  logic [NUM_CH-1:0][SEL_W-1:0] sel_q,
  output logic [NUM_CH-1:0]            pin_val,
  output logic [NUM_CH-1:0]            pin_ok
);
  logic [SEL_SPAN-1:0] padded;
  assign padded = SEL_SPAN'(gpio_in);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign pin_ok[c]  = (sel_q[c] < SEL_W'(NUM_PINS));
    assign pin_val[c] = padded[sel_q[c]] & pin_ok[c];
  end
endmodule

// File: rtl/gir_trig.sv
module gir_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic gen,
  input  logic any_tr,
  input  logic edge_mode,
  input  logic pol,
  input  logic pin,
  input  logic pin_ok,
  input  logic sel_wr,
  output logic irq,
  output logic prev_q
);
  logic fresh_q;
  logic changed;
  logic fire;

  always_comb begin
    changed = (pin ^ prev_q) & ~fresh_q;
    if (any_tr)         fire = changed;
    else if (edge_mode) fire = changed & (pin ^ pol);
    else                fire = pin ^ pol;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      fresh_q <= 1'b0;
      irq     <= 1'b0;
    end else begin
      prev_q  <= pin;
      fresh_q <= sel_wr;
      irq     <= gen & pin_ok & fire;
    end
  end
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gir_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  input  logic [NUM_PINS-1:0]  gpio_in,
  output logic [NUM_CH-1:0]    irq_out
);
  ctrl_t                        ctrl_q;
  logic [NUM_CH-1:0][SEL_W-1:0] sel_q;
  logic [NUM_CH-1:0]            sel_wr;
  logic [NUM_CH-1:0]            pin_val;
  logic [NUM_CH-1:0]            pin_ok;
  logic [NUM_CH-1:0]            prev_q;

  gir_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .ctrl_q  (ctrl_q),
    .sel_q   (sel_q),
    .sel_wr  (sel_wr)
  );

  gir_mux u_mux (
    .gpio_in (gpio_in),
    .sel_q   (sel_q),
    .pin_val (pin_val),
    .pin_ok  (pin_ok)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_line
    gir_trig u_trig (
      .clk       (clk),
      .rst_n     (rst_n),
      .gen       (ctrl_q.gen),
      .any_tr    (ctrl_q.any_tr[c]),
      .edge_mode (ctrl_q.edge_mode[c]),
      .pol       (ctrl_q.pol[c]),
      .pin       (pin_val[c]),
      .pin_ok    (pin_ok[c]),
      .sel_wr    (sel_wr[c]),
      .irq       (irq_out[c]),
      .prev_q    (prev_q[c])
    );
  end
endmodule

// File: rtl/gir_chk.sv
module gir_chk
  import gir_pkg::*;
(
  input logic                         clk,
  input logic                         rst_n,
  input logic [ADDR_W-1:0]            rd_addr,
  input logic [DATA_W-1:0]            rd_data,
  input logic [NUM_CH-1:0]            irq_out,
  input ctrl_t                        ctrl_q,
  input logic [NUM_CH-1:0][SEL_W-1:0] sel_q,
  input logic [NUM_CH-1:0]            pin_val,
  input logic [NUM_CH-1:0]            pin_ok,
  input logic [NUM_CH-1:0]            prev_q
);
  logic rd_mapped;
  always_comb begin
    rd_mapped = (rd_addr == ADDR_W'(CTRL_OFS));
    for (int k = 0; k < NUM_SEL_REGS; k++)
      if (rd_addr == ADDR_W'(SEL_BASE + REG_STRIDE * k)) rd_mapped = 1'b1;
  end

  // R3
  gen_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.gen |=> (irq_out == '0));

  // R10
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_mapped |-> (rd_data == '0));

  // R2
  ctrl_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == ADDR_W'(CTRL_OFS)) |-> (rd_data[GEN_BIT-1:ANY_LSB+NUM_CH] == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // R5
    sel_invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q[c] >= SEL_W'(NUM_PINS)) |=> !irq_out[c]);

    // R8
    any_still_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.any_tr[c] && (pin_val[c] == prev_q[c])) |=> !irq_out[c]);

    // R7
    edge_still_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.edge_mode[c] && (pin_val[c] == prev_q[c])) |=> !irq_out[c]);

    // R6
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.gen && pin_ok[c] && !ctrl_q.any_tr[c] && !ctrl_q.edge_mode[c])
        |=> (irq_out[c] == $past(pin_val[c] ^ ctrl_q.pol[c])));
  end
endmodule

bind gpio_irq_router gir_chk u_chk (.*);

// File: tb/sim_gpio_irq_router.sv
`timescale 1ns/1ps
module sim_gpio_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [61:0] gpio_in = '0;
  logic [7:0]  irq_out;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  gpio_irq_router u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .gpio_in(gpio_in), .irq_out(irq_out)
  );

  // reference state built from the requirements
  logic [31:0] m_ctrl = '0;
  int          m_sel [8];
  logic [7:0]  m_prev = '0;
  logic [7:0]  m_fresh = '0;
  logic [61:0] g = '0;

  function automatic logic m_ok(int c);
    return m_sel[c] < 62;
  endfunction

  function automatic logic m_pin(int c);
    if (!m_ok(c)) return 1'b0;
    return gpio_in[m_sel[c]];
  endfunction

  function automatic logic m_fire(int c);
    logic p, any_b, edg, pol, ch;
    p     = m_pin(c);
    any_b = m_ctrl[16+c];
    edg   = m_ctrl[8+c];
    pol   = m_ctrl[c];
    ch    = (p != m_prev[c]) && !m_fresh[c];
    if (!m_ctrl[31] || !m_ok(c)) return 1'b0;
    if (any_b) return ch;
    if (edg)   return ch && (pol ? !p : p);
    return p ^ pol;
  endfunction

  function automatic string m_tag(int c);
    if (!m_ctrl[31]) return "R3";
    if (!m_ok(c)) return "R5";
    if (m_fresh[c] && (m_ctrl[16+c] || m_ctrl[8+c])) return "R9";
    if (m_ctrl[16+c]) return "R8";
    if (m_ctrl[8+c]) return "R7";
    return "R6";
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    if (a == 8'h00) return m_ctrl;
    for (int k = 0; k < 4; k++)
      if (a == 8'(4 + 4*k))
        return {9'b0, 7'(m_sel[2*k+1]), 9'b0, 7'(m_sel[2*k])};
    return 32'h0;
  endfunction

  task automatic model_edge(logic we, logic [7:0] a, logic [31:0] d);
    logic [7:0] pv;
    for (int c = 0; c < 8; c++) pv[c] = m_pin(c);
    m_prev  = pv;
    m_fresh = '0;
    if (we) begin
      if (a == 8'h00) m_ctrl = d & 32'h80FF_FFFF;
      for (int k = 0; k < 4; k++) begin
        if (a == 8'(4 + 4*k)) begin
          m_sel[2*k]     = int'(d[6:0]);
          m_sel[2*k+1]   = int'(d[22:16]);
          m_fresh[2*k]   = 1'b1;
          m_fresh[2*k+1] = 1'b1;
        end
      end
    end
  endtask

  // one clock: drive at falling edge, check the registered outputs a cycle later
  task automatic step(logic we, logic [7:0] a, logic [31:0] d);
    logic [7:0] exp;
    string      tags [8];
    wr_en = we; wr_addr = a; wr_data = d; gpio_in = g;
    #1;
    for (int c = 0; c < 8; c++) begin
      exp[c]  = m_fire(c);
      tags[c] = m_tag(c);
    end
    @(posedge clk);
    model_edge(we, a, d);
    @(negedge clk);
    wr_en = 1'b0;
    for (int c = 0; c < 8; c++) begin
      checks++;
      if (irq_out[c] !== exp[c]) begin
        fails++;
        $display("FAIL %s ch%0d irq actual=%b expected=%b", tags[c], c, irq_out[c], exp[c]);
      end
    end
  endtask

  task automatic rd_chk(logic [7:0] a, string tag);
    logic [31:0] exp;
    exp = m_read(a);
    rd_addr = a;
    #1;
    checks++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s read 0x%02h actual=0x%08h expected=0x%08h", tag, a, rd_data, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int c = 0; c < 8; c++) m_sel[c] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    checks++;
    if (irq_out !== 8'h00) begin
      fails++;
      $display("FAIL R1 irq actual=%h expected=00", irq_out);
    end
    for (int k = 0; k < 5; k++) rd_chk(8'(4*k), "R1");

    // R2 / R4: field layout and reserved bits
    step(1'b1, 8'h00, 32'hFFFF_FFFF);
    rd_chk(8'h00, "R2");
    step(1'b1, 8'h04, 32'hFFFF_FFFF);
    rd_chk(8'h04, "R4");
    step(1'b1, 8'h00, 32'h0);

    // R10: unmapped offsets
    step(1'b1, 8'h14, 32'hFFFF_FFFF);
    step(1'b1, 8'h02, 32'hFFFF_FFFF);
    rd_chk(8'h14, "R10");
    rd_chk(8'h02, "R10");
    rd_chk(8'hFC, "R10");
    rd_chk(8'h00, "R10");
    rd_chk(8'h08, "R10");

    // directed line setup: ch0 pin3 ch1 pin5 ch2 pin10 ch3 pin61
    // ch4 sel 62, ch5 sel 127, ch6 pin0, ch7 pin20
    step(1'b1, 8'h04, (32'd5  << 16) | 32'd3);
    step(1'b1, 8'h08, (32'd61 << 16) | 32'd10);
    step(1'b1, 8'h0C, (32'd127 << 16) | 32'd62);
    step(1'b1, 8'h10, (32'd20 << 16) | 32'd0);
    rd_chk(8'h0C, "R4");
    step(1'b1, 8'h00, 32'h80C0_6C5A);
    rd_chk(8'h00, "R2");
    repeat (2) step(1'b0, 8'h00, 32'h0);

    // walk each watched pin high then low (R5 R6 R7 R8)
    for (int i = 0; i < 6; i++) begin
      int pin_list [6] = '{3, 5, 10, 61, 0, 20};
      g[pin_list[i]] = 1'b1; step(1'b0, 8'h00, 32'h0);
      step(1'b0, 8'h00, 32'h0);
      g[pin_list[i]] = 1'b0; step(1'b0, 8'h00, 32'h0);
      step(1'b0, 8'h00, 32'h0);
    end
    g = '1; repeat (3) step(1'b0, 8'h00, 32'h0);
    g = '0; repeat (3) step(1'b0, 8'h00, 32'h0);

    // R9: reselect ch2 (rising edge) from low pin10 to high pin11
    g[11] = 1'b1; step(1'b0, 8'h00, 32'h0);
    step(1'b1, 8'h08, (32'd61 << 16) | 32'd11);
    repeat (3) step(1'b0, 8'h00, 32'h0);
    g[11] = 1'b0; step(1'b0, 8'h00, 32'h0);

    // R3: global enable off while pins toggle
    step(1'b1, 8'h00, 32'h00C0_6C5A);
    for (int i = 0; i < 6; i++) begin
      g = ~g; step(1'b0, 8'h00, 32'h0);
    end
    step(1'b1, 8'h00, 32'h80C0_6C5A);

    // constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      logic        we;
      logic [7:0]  a;
      logic [31:0] d;
      int          pick;
      we   = ($urandom % 6) == 0;
      pick = $urandom % 8;
      a    = (pick < 5) ? 8'(4*pick) : ((pick == 5) ? 8'h14 : ((pick == 6) ? 8'h06 : 8'h00));
      d    = $urandom;
      d[6:0]   = 7'($urandom % 70);
      d[22:16] = 7'($urandom % 70);
      if (a == 8'h00) d[31] = ($urandom % 5) != 0;
      if (($urandom % 4) == 0) g = {$urandom, $urandom};
      else g[$urandom % 62] = ~g[$urandom % 62];
      step(we, a, d);
      if ((n % 50) == 0) begin
        rd_chk(8'h00, "R2");
        rd_chk(8'(4 + 4*($urandom % 4)), "R4");
        rd_chk(8'h18, "R10");
      end
    end

    summary();
    $finish;
  end
endmodule